// File: doc/BRIEF.md
# Transmit Event Statistics Counter

This block keeps four small event tallies for an Ethernet transmitter. The counted events are single collisions, multiple collisions, deferred transmissions and excessively deferred transmissions. Each tally is one nibble of a 16-bit word that the host reads. Every tally advances on a one-cycle event pulse from the transmit logic. When any tally wraps from its maximum value to zero, a sticky wrap flag is set. That flag can raise an interrupt request, but only while a separate enable input is high.

The host reads the word through a read strobe. In the strobe cycle it sees the current tallies. At the following clock edge all four tallies return to zero and the wrap flag clears. Until that read happens, the interrupt request stays asserted, so software must read the word to silence it. An event that arrives in the same cycle as the read is not lost: its tally restarts at one.

Top module: `txev_stat_counter`

## Requirements
- R1: A synchronous reset drives `cnt_word` to 0x0000 and drives both `wrap_flag` and `irq` to 0 at the clock edge where reset is high.
- R2: Field layout of `cnt_word`:
  - bits 3:0 count pulses on `ev_pulse[0]` (single collision);
  - bits 7:4 count `ev_pulse[1]` (multiple collision);
  - bits 11:8 count `ev_pulse[2]` (deferred);
  - bits 15:12 count `ev_pulse[3]` (excessively deferred).
  
  A pulse adds one to its own nibble at the next clock edge and leaves the other nibbles unchanged.
- R3: In a cycle with no event pulse and no read strobe, `cnt_word` holds its value.
- R4: A pulse on a nibble that holds 15 makes that nibble 0 at the next edge, and `wrap_flag` is 1 from that same edge.
- R5: Once `wrap_flag` is set, it stays at 1 through further events and idle cycles until a read. It also stays set if several nibbles wrap together.
- R6: While `rd_stb` is high, `cnt_word` shows the tallies from before the read. At the next edge every nibble without a concurrent pulse becomes 0, and `wrap_flag` becomes 0.
- R7: A pulse in the same cycle as `rd_stb` leaves its nibble at 1 after that edge.
- R8: `irq` is registered. At each edge it takes the value of the updated wrap flag ANDed with `wrap_irq_en` as sampled at that edge. With the enable low, `irq` stays 0 while the flag is set. Raising the enable asserts `irq` at the next edge.
- R9: While the flag is set and the enable is high, `irq` remains 1 cycle after cycle. It falls at the edge that ends a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 4 | One-cycle event pulses, bit i feeds nibble i |
| rd_stb | input | 1 | Host read of the counter word (clears on next edge) |
| wrap_irq_en | input | 1 | Allows the wrap flag to request an interrupt |
| cnt_word | output | 16 | Packed nibble tallies |
| wrap_flag | output | 1 | Sticky flag: a nibble has wrapped since the last read |
| irq | output | 1 | Registered interrupt request |

## Verification
A nibble that counts wrongly or a slip in the packing shows on `cnt_word` at the very next edge after the offending pulse. The per-cycle comparison therefore points to the exact event that went astray. Errors in the wrap flag appear at two ports. A flag that never sets shows on `wrap_flag` one edge after the sixteenth pulse. A flag that forgets its state shows during the idle cycles that follow. A wrongly gated or stale request shows on `irq` either in the cycle after the enable changes or in the cycle after a read. Reads that coincide with pulses check that the clear and the increment combine correctly.

// File: rtl/txev_pkg.sv
package txev_pkg;
  parameter int unsigned EV_COUNT = 4;
  parameter int unsigned CTR_BITS = 4;
  localparam int unsigned WORD_BITS = EV_COUNT * CTR_BITS;
endpackage

// File: rtl/txev_ctr.sv
module txev_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] base;

  always_comb begin
    base = clr ? '0 : q;
    wrap = inc && !clr && (&q);
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (inc) q <= base + ONE;
    else          q <= base;
  end

  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == W'($past(inc)))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(q)); // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (q == '0)); // R4
endmodule

// File: rtl/txev_wrap_flag.sv
module txev_wrap_flag (
  input  logic clk,
  input  logic rst,
  input  logic wrap_any,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_nx;

  always_comb flag_nx = (flag && !clr) || wrap_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nx;
      irq  <= flag_nx && irq_en;
    end
  end

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    wrap_any |=> flag); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag); // R5
  AST_READ_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (clr && !wrap_any) |=> !flag); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq); // R8
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr && irq_en) |=> irq); // R9
endmodule

// File: rtl/txev_stat_counter.sv
module txev_stat_counter #(
  parameter int unsigned N_EV = txev_pkg::EV_COUNT,
  parameter int unsigned CW   = txev_pkg::CTR_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EV-1:0]  ev_pulse,
  input  logic             rd_stb,
  input  logic             wrap_irq_en,
  output logic [N_EV*CW-1:0] cnt_word,
  output logic             wrap_flag,
  output logic             irq
);
  localparam int unsigned WW = N_EV * CW;

  logic [N_EV-1:0] wrap_vec;

  for (genvar g = 0; g < N_EV; g++) begin : g_ctr
    txev_ctr #(.W(CW)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .clr  (rd_stb),
      .inc  (ev_pulse[g]),
      .q    (cnt_word[g*CW +: CW]),
      .wrap (wrap_vec[g])
    );
  end

  txev_wrap_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .wrap_any (|wrap_vec),
    .clr      (rd_stb),
    .irq_en   (wrap_irq_en),
    .flag     (wrap_flag),
    .irq      (irq)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt_word == WW'(0) && !wrap_flag && !irq)); // R1
  AST_READ_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && ev_pulse == '0) |=> (cnt_word == WW'(0))); // R6
endmodule

// File: tb/sim_txev_stat_counter.sv
`timescale 1ns/1ps
module sim_txev_stat_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ev_pulse = 4'h0;
  logic        rd_stb = 1'b0;
  logic        wrap_irq_en = 1'b0;
  logic [15:0] cnt_word;
  logic        wrap_flag;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [17:0] exp_q[$];
  string       tag_q[$];

  int  m_cnt [4];
  bit  m_flag = 1'b0;
  bit  m_irq  = 1'b0;

  always #2 clk = ~clk;

  txev_stat_counter u0 (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .rd_stb(rd_stb),
    .wrap_irq_en(wrap_irq_en), .cnt_word(cnt_word),
    .wrap_flag(wrap_flag), .irq(irq)
  );

  task automatic step(input bit r, input logic [3:0] e, input bit rd,
                      input bit en, input string tag);
    bit wr;
    logic [15:0] w;
    @(negedge clk);
    rst = r; ev_pulse = e; rd_stb = rd; wrap_irq_en = en;
    wr = 1'b0;
    if (r) begin
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
      m_flag = 1'b0; m_irq = 1'b0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        int b;
        b = rd ? 0 : m_cnt[i];
        if (e[i]) begin
          if (b == 15) wr = 1'b1;
          m_cnt[i] = (b + 1) % 16;
        end else m_cnt[i] = b;
      end
      m_flag = (m_flag && !rd) || wr;
      m_irq  = m_flag && en;
    end
    w = {m_cnt[3][3:0], m_cnt[2][3:0], m_cnt[1][3:0], m_cnt[0][3:0]};
    exp_q.push_back({w, m_flag, m_irq});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [17:0] ex;
      string t;
      ex = exp_q.pop_front();
      t  = tag_q.pop_front();
      n_vec++;
      if ({cnt_word, wrap_flag, irq} !== ex) begin
        n_bad++;
        $display("FAIL %s: got word=%h flag=%b irq=%b, expected word=%h flag=%b irq=%b",
                 t, cnt_word, wrap_flag, irq, ex[17:2], ex[1], ex[0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired (R1..R9 incomplete): got running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(1, 4'h0, 0, 0, "R1 reset");
    step(1, 4'h0, 0, 1, "R1 reset");
    // R2: each pulse lands in its own nibble
    step(0, 4'h1, 0, 1, "R2 single nibble");
    step(0, 4'h2, 0, 1, "R2 multi nibble");
    step(0, 4'h4, 0, 1, "R2 defer nibble");
    step(0, 4'h8, 0, 1, "R2 xdefer nibble");
    step(0, 4'h5, 0, 1, "R2 mixed");
    // R3: idle holds
    for (int i = 0; i < 3; i++) step(0, 4'h0, 0, 1, "R3 idle hold");
    // R6: read shows value then clears
    step(0, 4'h0, 1, 1, "R6 read cycle");
    step(0, 4'h0, 0, 1, "R6 after read");
    // R4: wrap nibble 0 with enable high
    for (int i = 0; i < 16; i++) step(0, 4'h1, 0, 1, "R4 count to wrap");
    step(0, 4'h0, 0, 1, "R8 irq on flag");
    // R5: flag sticky through events and idle
    step(0, 4'h2, 0, 1, "R5 sticky event");
    for (int i = 0; i < 3; i++) step(0, 4'h0, 0, 1, "R9 irq held");
    // R7: event during read restarts at one
    step(0, 4'h4, 1, 1, "R7 read with pulse");
    step(0, 4'h0, 0, 1, "R9 irq dropped");
    // R8: enable low keeps irq quiet
    for (int i = 0; i < 16; i++) step(0, 4'h8, 0, 0, "R8 wrap disabled");
    step(0, 4'h0, 0, 0, "R8 irq gated");
    step(0, 4'h0, 0, 1, "R8 enable raised");
    step(0, 4'h0, 1, 1, "R9 read clears irq");
    step(0, 4'h0, 0, 1, "R9 after read");
    // R5: all nibbles wrap together
    for (int i = 0; i < 16; i++) step(0, 4'hF, 0, 1, "R5 joint wrap");
    step(0, 4'h0, 0, 1, "R5 joint hold");
    step(0, 4'hB, 1, 0, "R7 read with multi pulse");
    // mixed patterns
    for (int i = 0; i < 40; i++)
      step(0, 4'((i * 7 + 3) % 16) & ~((i % 3 == 0) ? 4'h2 : 4'h1),
           (i % 11) == 10, (i % 5) != 0, "R2 mixed stream");
    step(1, 4'hF, 0, 1, "R1 reset mid-run");
    step(0, 4'h0, 0, 1, "R3 idle after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule